// File: doc/BRIEF.md
# Table-Coded Clock-Enable Divider with Gate

This block turns a free-running clock into one or more divided clock-enable strands. Each strand is a single-cycle pulse repeated once every N input cycles. N is not the programmed value plus one. A 4-bit code selects it from a fixed, sparse table, and that table contains ratios that are not powers of two, such as 3, 10, 18 and 36. A compile-time parameter chooses one of three tables.

The block holds one control register that can be written and read back. With the gated table, the register holds one code field and a stop bit. Writing 1 to the stop bit halts the strand, and clearing it restarts the divider from zero. With either of the two ungated tables, the register holds three code fields. Each field drives its own strand, and the strands run independently.

A new ratio never cuts a period short. The running period completes first, and the new ratio starts at the next boundary. A code that is missing from the selected table silences its strand and raises a status bit for that strand.

Top module: `clkdiv_table_gate`

## Requirements
- R1: While reset is held, every enable and status output reads 0 except the invalid flags of lanes whose reset code is not in the table. The readback is 16'h0100 for the gated table and 0 for the others. The block starts counting on the third clock edge after rst_n rises.
- R2: Gated table (TABLE = TBL_GATED), code in bits 3:0. Codes 1 to 8 give periods of 3, 4, 6, 8, 12, 16, 18 and 24 cycles. Code 10 gives 36 and code 11 gives 48. Every other code is invalid.
- R3: Full table (TABLE = TBL_FULL). Code 0 gives a period of 2, and all other codes map as in R2.
- R4: Sparse table (TABLE = TBL_SPARSE). Codes 4 to 8 give 8, 12, 16, 18 and 24. Code 10 gives 36, code 11 gives 48 and code 12 gives 10. Every other code is invalid.
- R5: A running lane drives clk_en_o high for exactly one cycle out of every N. After a write starts a stopped lane with ratio N, the first pulse is visible in the cycle that follows the N-th clock edge after the edge that stores the write.
- R6: Writing a new valid code while a lane runs does not change the period in progress. The new ratio applies from the next pulse onward.
- R7: When a lane's code is invalid, code_bad_o for that lane is 1 from the cycle after the write. Its clk_en_o is 0 from the following edge onward.
- R8: Gated table only. Bit 8 = 1 stops lane 0 from the next edge. Writing it back to 0 restarts the count at zero, as in R5.
- R9: Readback returns the last written value ANDed with the stored-bit mask: 16'h010F for the gated table and 16'h0FFF otherwise. In the gated table only lane 0 exists, and the enable and status bits of lanes 1 and 2 read 0.
- R10: For the ungated tables, lane k takes its code from bits 4k+3:4k, and each lane's period depends only on its own field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write strobe for the control register |
| wr_data_i | input | REG_W | Write data |
| rd_data_o | output | REG_W | Control register readback |
| clk_en_o | output | 3 | One divided enable strand per lane |
| code_bad_o | output | 3 | Lane code not in the selected table |

## Verification
- **Readback and status:** the write is stored on the clock edge that samples the strobe. Readback and the invalid flags change on that same edge and are compared half a cycle later.
- **Enable pulses:** each enable is registered after the divider counter, so it lags the stored code by one edge. A lane started from rest pulses first after N further edges.
- **Per-cycle comparison:** a behavioural model in the bench applies the same edge ordering to all three table variants. On every falling edge it compares every output with the model.
- **Directed checks:** these count falling edges from the write-return point or from a pulse. They measure first-pulse latency, periods and the hold-over of the old ratio across a code change.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int CODE_W   = 4;
  localparam int RATIO_W  = 6;
  localparam int LANES    = 3;
  localparam int GATE_BIT = 8;

  typedef enum logic [1:0] {
    TBL_GATED  = 2'd0,
    TBL_FULL   = 2'd1,
    TBL_SPARSE = 2'd2
  } tbl_e;

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [CODE_W-1:0]  code_t;

  // Returns the period in cycles for a code; zero marks an invalid code.
  function automatic ratio_t ratio_of(tbl_e t, code_t c);
    ratio_t r;
    case (c)
      4'd0:    r = (t == TBL_FULL)   ? ratio_t'(2)  : '0;
      4'd1:    r = (t == TBL_SPARSE) ? '0 : ratio_t'(3);
      4'd2:    r = (t == TBL_SPARSE) ? '0 : ratio_t'(4);
      4'd3:    r = (t == TBL_SPARSE) ? '0 : ratio_t'(6);
      4'd4:    r = ratio_t'(8);
      4'd5:    r = ratio_t'(12);
      4'd6:    r = ratio_t'(16);
      4'd7:    r = ratio_t'(18);
      4'd8:    r = ratio_t'(24);
      4'd10:   r = ratio_t'(36);
      4'd11:   r = ratio_t'(48);
      4'd12:   r = (t == TBL_SPARSE) ? ratio_t'(10) : '0;
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg
  import clkdiv_pkg::*;
#(
  parameter tbl_e TABLE = TBL_GATED,
  parameter int   REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] ctrl_o
);
  localparam bit               GATED     = (TABLE == TBL_GATED);
  localparam logic [REG_W-1:0] CODE_MASK = REG_W'((1 << CODE_W) - 1);
  localparam logic [REG_W-1:0] ALL_MASK  = REG_W'((1 << (CODE_W * LANES)) - 1);
  localparam logic [REG_W-1:0] GATE_ONE  = REG_W'(1) << GATE_BIT;
  localparam logic [REG_W-1:0] KEEP_MASK = GATED ? (GATE_ONE | CODE_MASK) : ALL_MASK;
  localparam logic [REG_W-1:0] RST_VAL   = GATED ? GATE_ONE : '0;

  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] ctrl_d;
  logic             ctrl_ce;

  always_comb begin
    ctrl_ce = wr_en_i;
    ctrl_d  = wr_data_i & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= RST_VAL;
    end else if (ctrl_ce) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import clkdiv_pkg::*;
#(
  parameter tbl_e TABLE = TBL_GATED
) (
  input  code_t  code_i,
  output ratio_t ratio_o,
  output logic   valid_o
);
  always_comb begin
    ratio_o = ratio_of(TABLE, code_i);
    valid_o = (ratio_o != '0);
  end
endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane
  import clkdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   active_i,
  input  ratio_t ratio_i,
  output logic   en_o
);
  ratio_t cnt_q, cnt_d;
  ratio_t per_q, per_d;
  ratio_t eff;
  logic   run_q, run_d;
  logic   en_q, en_d;
  logic   wrap;

  // The held period applies while running; a fresh start takes the new ratio.
  always_comb begin
    eff  = run_q ? per_q : ratio_i;
    wrap = (cnt_q == ratio_t'(eff - ratio_t'(1)));
    if (!active_i) begin
      cnt_d = '0;
      per_d = ratio_i;
      run_d = 1'b0;
      en_d  = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      per_d = ratio_i;
      run_d = 1'b1;
      en_d  = 1'b1;
    end else begin
      cnt_d = ratio_t'(cnt_q + ratio_t'(1));
      per_d = eff;
      run_d = 1'b1;
      en_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      run_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      run_q <= run_d;
      en_q  <= en_d;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/clkdiv_table_gate.sv
module clkdiv_table_gate
  import clkdiv_pkg::*;
#(
  parameter tbl_e TABLE = TBL_GATED,
  parameter int   REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [LANES-1:0] clk_en_o,
  output logic [LANES-1:0] code_bad_o
);
  localparam bit GATED     = (TABLE == TBL_GATED);
  localparam int ACT_LANES = GATED ? 1 : LANES;

  logic             rst_int_n;
  logic [REG_W-1:0] ctrl;
  logic             stop;

  clkdiv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  clkdiv_ctrl_reg #(.TABLE(TABLE), .REG_W(REG_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl)
  );

  assign stop      = GATED ? ctrl[GATE_BIT] : 1'b0;
  assign rd_data_o = ctrl;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i < ACT_LANES) begin : g_on
      ratio_t ratio;
      logic   valid;

      clkdiv_decode #(.TABLE(TABLE)) u_dec (
        .code_i  (ctrl[i*CODE_W +: CODE_W]),
        .ratio_o (ratio),
        .valid_o (valid)
      );

      clkdiv_lane u_lane (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .active_i (valid & ~stop),
        .ratio_i  (ratio),
        .en_o     (clk_en_o[i])
      );

      assign code_bad_o[i] = ~valid;
    end else begin : g_off
      assign clk_en_o[i]   = 1'b0;
      assign code_bad_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/clkdiv_table_gate_chk.sv
module clkdiv_table_gate_chk
  import clkdiv_pkg::*;
#(
  parameter tbl_e TABLE = TBL_GATED,
  parameter int   REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic [LANES-1:0] clk_en_o,
  input logic [LANES-1:0] code_bad_o
);
  localparam bit               GATED = (TABLE == TBL_GATED);
  localparam logic [REG_W-1:0] KEEP  = GATED ? REG_W'(16'h010F) : REG_W'(16'h0FFF);

  // R9: stored value seen on readback one edge after the write
  p_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (rd_data_o == ($past(wr_data_i) & KEEP)));

  for (genvar i = 0; i < LANES; i++) begin : g_a
    // R5: pulses last one cycle
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_o[i] |=> !clk_en_o[i]);
    // R7: an invalid code silences the lane from the next edge
    p_bad_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      code_bad_o[i] |=> !clk_en_o[i]);
  end

  if (GATED) begin : g_gate
    // R8: stop bit halts lane 0
    p_gate_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[GATE_BIT] |=> !clk_en_o[0]);
    // R9: lanes 1 and 2 stay quiet
    p_idle_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en_o[2:1] == 2'b00) && (code_bad_o[2:1] == 2'b00));
  end
endmodule

bind clkdiv_table_gate clkdiv_table_gate_chk #(.TABLE(TABLE), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .clk_en_o   (clk_en_o),
  .code_bad_o (code_bad_o)
);

// File: tb/tb_clkdiv_table_gate.sv
module tb_clkdiv_table_gate;
  import clkdiv_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_g = '0;
  logic [15:0] wr_u = '0;
  logic [15:0] rd_v [3];
  logic [2:0]  en_v [3];
  logic [2:0]  bad_v [3];

  int n_chk = 0;
  int n_bad = 0;
  bit started = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clkdiv_table_gate #(.TABLE(TBL_GATED), .REG_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_g),
    .rd_data_o(rd_v[0]), .clk_en_o(en_v[0]), .code_bad_o(bad_v[0]));
  clkdiv_table_gate #(.TABLE(TBL_FULL), .REG_W(16)) dut_full (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_u),
    .rd_data_o(rd_v[1]), .clk_en_o(en_v[1]), .code_bad_o(bad_v[1]));
  clkdiv_table_gate #(.TABLE(TBL_SPARSE), .REG_W(16)) dut_sparse (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_u),
    .rd_data_o(rd_v[2]), .clk_en_o(en_v[2]), .code_bad_o(bad_v[2]));

  // Period table taken from the requirements; 0 means invalid.
  function automatic int exp_div(int v, int c);
    int r;
    case (c)
      0: r = (v == 1) ? 2 : 0;
      1: r = (v == 2) ? 0 : 3;
      2: r = (v == 2) ? 0 : 4;
      3: r = (v == 2) ? 0 : 6;
      4: r = 8;  5: r = 12; 6: r = 16; 7: r = 18; 8: r = 24;
      10: r = 36; 11: r = 48;
      12: r = (v == 2) ? 10 : 0;
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic int keep_mask(int v);
    return (v == 0) ? 16'h010F : 16'h0FFF;
  endfunction

  function automatic int rst_ctrl(int v);
    return (v == 0) ? 16'h0100 : 0;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int  m_ctrl [3];
  int  m_cnt [3][3];
  int  m_per [3][3];
  bit  m_run [3][3];
  bit  m_en [3][3];
  bit  m_s0 = 0;
  bit  m_s1 = 0;

  function automatic int lane_code(int v, int l);
    return (m_ctrl[v] >> (4 * l)) & 15;
  endfunction

  function automatic bit lane_exists(int v, int l);
    return (v != 0) || (l == 0);
  endfunction

  task automatic model_reset();
    for (int v = 0; v < 3; v++) begin
      m_ctrl[v] = rst_ctrl(v);
      for (int l = 0; l < 3; l++) begin
        m_cnt[v][l] = 0; m_per[v][l] = 0; m_run[v][l] = 0; m_en[v][l] = 0;
      end
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    bit op;
    op = m_s1;
    m_s1 = rst_n ? m_s0 : 1'b0;
    m_s0 = rst_n;
    if (!op) begin
      model_reset();
    end else begin
      for (int v = 0; v < 3; v++) begin
        for (int l = 0; l < 3; l++) begin
          int d;
          int eff;
          bit go;
          d  = exp_div(v, lane_code(v, l));
          go = lane_exists(v, l) && (d != 0) && !((v == 0) && m_ctrl[0][8]);
          if (!go) begin
            m_cnt[v][l] = 0; m_per[v][l] = d; m_run[v][l] = 0; m_en[v][l] = 0;
          end else begin
            eff = m_run[v][l] ? m_per[v][l] : d;
            m_run[v][l] = 1;
            if (m_cnt[v][l] == eff - 1) begin
              m_cnt[v][l] = 0; m_per[v][l] = d; m_en[v][l] = 1;
            end else begin
              m_cnt[v][l]++; m_per[v][l] = eff; m_en[v][l] = 0;
            end
          end
        end
      end
      if (wr_en) begin
        m_ctrl[0] = int'(wr_g) & keep_mask(0);
        m_ctrl[1] = int'(wr_u) & keep_mask(1);
        m_ctrl[2] = int'(wr_u) & keep_mask(2);
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      for (int v = 0; v < 3; v++) begin
        int ee;
        int eb;
        ee = 0; eb = 0;
        for (int l = 0; l < 3; l++) begin
          if (m_en[v][l]) ee |= (1 << l);
          if (lane_exists(v, l) && exp_div(v, lane_code(v, l)) == 0) eb |= (1 << l);
        end
        check("R5", $sformatf("enables v%0d", v), int'(en_v[v]), ee);
        check("R7", $sformatf("invalid flags v%0d", v), int'(bad_v[v]), eb);
        check("R9", $sformatf("readback v%0d", v), int'(rd_v[v]), m_ctrl[v]);
      end
    end
  end

  task automatic write(logic [15:0] g, logic [15:0] u);
    @(negedge clk);
    wr_en = 1'b1; wr_g = g; wr_u = u;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Waits for a pulse after the current negedge, then counts to the next one.
  task automatic measure(int v, int l, output int period);
    int k;
    period = -1;
    k = 0;
    while (k < 200) begin
      @(posedge clk); @(negedge clk); k++;
      if (en_v[v][l]) break;
    end
    if (k >= 200) return;
    k = 0;
    while (k < 200) begin
      @(posedge clk); @(negedge clk); k++;
      if (en_v[v][l]) begin
        period = k;
        return;
      end
    end
  endtask

  task automatic lane_check(string tag, int v, int l, int code);
    int d;
    int p;
    int pulses;
    d = exp_div(v, code);
    if (d == 0) begin
      pulses = 0;
      repeat (60) begin
        @(posedge clk); @(negedge clk);
        if (en_v[v][l]) pulses++;
      end
      check(tag, $sformatf("v%0d lane%0d code %0d pulses", v, l, code), pulses, 0);
      check("R7", $sformatf("v%0d lane%0d code %0d flag", v, l, code), int'(bad_v[v][l]), 1);
    end else begin
      measure(v, l, p);
      check(tag, $sformatf("v%0d lane%0d code %0d period", v, l, code), p, d);
    end
  endtask

  initial begin
    int k;
    int p;
    repeat (3) @(negedge clk);
    // R1: values held in reset
    check("R1", "reset readback v0", int'(rd_v[0]), 16'h0100);
    check("R1", "reset readback v1", int'(rd_v[1]), 0);
    check("R1", "reset readback v2", int'(rd_v[2]), 0);
    check("R1", "reset enables v0", int'(en_v[0]), 0);
    check("R1", "reset enables v1", int'(en_v[1]), 0);
    check("R1", "reset invalid flags v2", int'(bad_v[2]), 7);
    rst_n = 1'b1;
    started = 1;
    repeat (5) @(negedge clk);

    // R2 / R3 / R4: every code in every table
    for (int c = 0; c < 16; c++) begin
      write(16'(c), 16'(c | (c << 4) | (c << 8)));
      lane_check("R2", 0, 0, c);
      for (int l = 0; l < 3; l++) begin
        lane_check("R3", 1, l, c);
        lane_check("R4", 2, l, c);
      end
    end

    // R10: distinct codes per field
    write(16'h0004, 16'h04A8);
    lane_check("R10", 1, 0, 8);
    lane_check("R10", 1, 1, 10);
    lane_check("R10", 1, 2, 4);
    lane_check("R10", 2, 0, 8);
    lane_check("R10", 2, 1, 10);
    lane_check("R10", 2, 2, 4);

    // R6: code change mid-period keeps the old period once
    write(16'h0008, 16'h0888);
    measure(0, 0, p);
    @(negedge clk);
    wr_en = 1'b1; wr_g = 16'h0002; wr_u = 16'h0222;
    k = 0;
    while (k < 100) begin
      @(posedge clk); @(negedge clk); k++;
      wr_en = 1'b0;
      if (en_v[0][0]) break;
    end
    check("R6", "old period kept", k + 1, 24);
    measure(0, 0, p);
    check("R6", "new period applied", p, 4);

    // R8: stop bit halts, clearing restarts from zero
    write(16'h0102, 16'h0222);
    k = 0;
    repeat (60) begin
      @(posedge clk); @(negedge clk);
      if (en_v[0][0]) k++;
    end
    check("R8", "pulses while stopped", k, 0);
    write(16'h0002, 16'h0222);
    k = 0;
    while (k < 100) begin
      @(posedge clk); @(negedge clk); k++;
      if (en_v[0][0]) break;
    end
    check("R8", "first pulse after restart", k, 4);
    check("R5", "first pulse latency ratio 4", k, 4);

    // R9: masked readback
    write(16'hFFFF, 16'hFFFF);
    check("R9", "masked readback v0", int'(rd_v[0]), 16'h010F);
    check("R9", "masked readback v1", int'(rd_v[1]), 16'h0FFF);
    check("R9", "unused lanes v0", int'({en_v[0][2:1], bad_v[0][2:1]}), 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule